// File: doc/BRIEF.md
# Accumulator and Link-Bit Unit

This block is the data-path register of a small accumulator machine. It holds a 16-bit accumulator together with a one-bit link flip-flop, and together they form a 17-bit extended register. A separate control unit decodes the instructions and fires one-cycle strobes. In each clock cycle the block applies the selected arithmetic, logic, shift or load operation to the accumulator and the link bit. The operands come from a 16-bit data-register value and an 8-bit input character.

The block also drives four condition outputs that the control unit's skip logic tests: accumulator positive, accumulator negative, accumulator zero, and link bit zero. These outputs are decoded directly from the registered state, so they always describe the current contents.

Top module: `acc_link_unit`

## Requirements
- R1: A synchronous reset (`rst` = 1 at a rising edge) clears the accumulator and the link bit to 0.
- R2: Strobe bit 1 (add) loads the low 16 bits of the accumulator plus the data value into the accumulator, and loads the carry out of bit 15 into the link bit.
- R3: Strobe bit 0 (and) loads the bitwise AND of the accumulator and the data value into the accumulator. The link bit keeps its value.
- R4: Strobe bit 2 (load) copies the data value into the accumulator. The link bit keeps its value.
- R5: Strobe bit 3 (input) loads the 8-bit character into accumulator bits 7..0. Bits 15..8 and the link bit keep their values.
- R6: Strobe bit 10 clears the accumulator. Strobe bit 9 clears the link bit. In each case the other register keeps its value.
- R7: Strobe bit 8 inverts every accumulator bit. Strobe bit 7 inverts the link bit. In each case the other register keeps its value.
- R8: Strobe bit 6 (rotate right) shifts the accumulator right by one bit, moves the old link bit into accumulator bit 15, and moves old accumulator bit 0 into the link bit.
- R9: Strobe bit 5 (rotate left) shifts the accumulator left by one bit, moves the old link bit into accumulator bit 0, and moves old accumulator bit 15 into the link bit.
- R10: Strobe bit 4 (increment) adds 1 to the accumulator modulo 2^16. The link bit is unchanged, including when the accumulator wraps from FFFF to 0000.
- R11: `cond_pos` is 1 when accumulator bit 15 is 0. `cond_neg` is 1 when accumulator bit 15 is 1. `cond_zero` is 1 when the accumulator is 0. `cond_ezero` is 1 when the link bit is 0.
- R12: When several strobe bits are 1 in the same cycle, only the highest-numbered one takes effect. When no strobe bit is 1, the accumulator and the link bit hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every update occurs on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_stb | input | 11 | One-cycle operation strobes; the bit assignment is given in the requirements |
| dr_val | input | 16 | Data-register operand |
| in_char | input | 8 | Input character |
| acc | output | 16 | Accumulator contents |
| link | output | 1 | Link bit |
| cond_pos | output | 1 | Accumulator bit 15 is 0 |
| cond_neg | output | 1 | Accumulator bit 15 is 1 |
| cond_zero | output | 1 | Accumulator is 0 |
| cond_ezero | output | 1 | Link bit is 0 |

## Verification
The whole state of the block appears on `acc` and `link`. A wrong next-state value therefore shows up at the ports one edge after the strobe that caused it. A fault in the link path can stay hidden until a later rotate or add consumes the link bit, so the bench checks the link bit directly after every operation and does not rely only on the results of later operations. Wrong priority among overlapping strobes shows as an accumulator or link value that matches a lower-priority operation. The bench compares every result against a reference model, with every operation starting from every combination of the link bit and a set of corner accumulator and data patterns.

// File: rtl/acc_pkg.sv
package acc_pkg;
    // Strobe bit positions; a higher index has higher priority.
    localparam int OP_AND = 0;
    localparam int OP_ADD = 1;
    localparam int OP_LDA = 2;
    localparam int OP_INP = 3;
    localparam int OP_INC = 4;
    localparam int OP_CIL = 5;
    localparam int OP_CIR = 6;
    localparam int OP_CME = 7;
    localparam int OP_CMA = 8;
    localparam int OP_CLE = 9;
    localparam int OP_CLA = 10;
    localparam int OP_N   = 11;
endpackage

// File: rtl/acc_op_prio.sv
module acc_op_prio #(
    parameter int N = 11
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    logic [N-1:0] grant_d;
    logic         taken_d;

    // Highest index wins.
    always_comb begin
        grant_d = '0;
        taken_d = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i] && !taken_d) begin
                grant_d[i] = 1'b1;
                taken_d    = 1'b1;
            end
        end
    end

    assign grant = grant_d;
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int W  = 16,
    parameter int CW = 8
) (
    input  logic [OP_N-1:0] grant,
    input  logic [W-1:0]    ac_q,
    input  logic            e_q,
    input  logic [W-1:0]    dr,
    input  logic [CW-1:0]   ch,
    output logic [W-1:0]    ac_d,
    output logic            e_d
);
    logic [W:0] sum_d;
    logic [W:0] inc_d;

    always_comb begin
        sum_d = {1'b0, ac_q} + {1'b0, dr};
        inc_d = {1'b0, ac_q} + {{W{1'b0}}, 1'b1};
        ac_d  = ac_q;
        e_d   = e_q;
        if (grant[OP_CLA]) begin
            ac_d = '0;
        end else if (grant[OP_CLE]) begin
            e_d = 1'b0;
        end else if (grant[OP_CMA]) begin
            ac_d = ~ac_q;
        end else if (grant[OP_CME]) begin
            e_d = ~e_q;
        end else if (grant[OP_CIR]) begin
            ac_d = {e_q, ac_q[W-1:1]};
            e_d  = ac_q[0];
        end else if (grant[OP_CIL]) begin
            ac_d = {ac_q[W-2:0], e_q};
            e_d  = ac_q[W-1];
        end else if (grant[OP_INC]) begin
            ac_d = inc_d[W-1:0];
        end else if (grant[OP_INP]) begin
            ac_d = {ac_q[W-1:CW], ch};
        end else if (grant[OP_LDA]) begin
            ac_d = dr;
        end else if (grant[OP_ADD]) begin
            ac_d = sum_d[W-1:0];
            e_d  = sum_d[W];
        end else if (grant[OP_AND]) begin
            ac_d = ac_q & dr;
        end
    end
endmodule

// File: rtl/acc_cond.sv
module acc_cond #(
    parameter int W = 16
) (
    input  logic [W-1:0] ac_q,
    input  logic         e_q,
    output logic         pos,
    output logic         neg,
    output logic         zero,
    output logic         ezero
);
    always_comb begin
        pos   = ~ac_q[W-1];
        neg   = ac_q[W-1];
        zero  = (ac_q == '0);
        ezero = ~e_q;
    end
endmodule

// File: rtl/acc_link_unit.sv
module acc_link_unit
    import acc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CHAR_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [OP_N-1:0]     op_stb,
    input  logic [DATA_W-1:0]   dr_val,
    input  logic [CHAR_W-1:0]   in_char,
    output logic [DATA_W-1:0]   acc,
    output logic                link,
    output logic                cond_pos,
    output logic                cond_neg,
    output logic                cond_zero,
    output logic                cond_ezero
);
    typedef struct packed {
        logic [DATA_W-1:0] ac;
        logic              e;
    } acc_state_t;

    acc_state_t        st_d, st_q;
    logic [OP_N-1:0]   grant;
    logic [DATA_W-1:0] ac_nx;
    logic              e_nx;

    acc_op_prio #(.N(OP_N)) u_prio (
        .req   (op_stb),
        .grant (grant)
    );

    acc_alu #(.W(DATA_W), .CW(CHAR_W)) u_alu (
        .grant (grant),
        .ac_q  (st_q.ac),
        .e_q   (st_q.e),
        .dr    (dr_val),
        .ch    (in_char),
        .ac_d  (ac_nx),
        .e_d   (e_nx)
    );

    acc_cond #(.W(DATA_W)) u_cond (
        .ac_q  (st_q.ac),
        .e_q   (st_q.e),
        .pos   (cond_pos),
        .neg   (cond_neg),
        .zero  (cond_zero),
        .ezero (cond_ezero)
    );

    always_comb begin
        st_d    = st_q;
        st_d.ac = ac_nx;
        st_d.e  = e_nx;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign acc  = st_q.ac;
    assign link = st_q.e;

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (acc == '0 && link == 1'b0));

    // R2: 17-bit result of a lone add
    a_r2_add_carry: assert property (@(posedge clk) disable iff (rst)
        (op_stb[OP_ADD] && op_stb[OP_N-1:OP_ADD+1] == '0)
        |=> ({link, acc} == {1'b0, $past(acc)} + {1'b0, $past(dr_val)}));

    // R5
    a_r5_inp_keeps_high: assert property (@(posedge clk) disable iff (rst)
        (op_stb[OP_INP] && op_stb[OP_N-1:OP_INP+1] == '0)
        |=> (acc[DATA_W-1:CHAR_W] == $past(acc[DATA_W-1:CHAR_W])
             && acc[CHAR_W-1:0] == $past(in_char) && $stable(link)));

    // R9
    a_r9_cil_ring: assert property (@(posedge clk) disable iff (rst)
        (op_stb[OP_CIL] && op_stb[OP_N-1:OP_CIL+1] == '0)
        |=> ({link, acc} == {$past(acc), $past(link)}));

    // R10
    a_r10_inc_keeps_e: assert property (@(posedge clk) disable iff (rst)
        (op_stb[OP_INC] && op_stb[OP_N-1:OP_INC+1] == '0) |=> $stable(link));

    // R12
    a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (op_stb == '0) |=> ($stable(acc) && $stable(link)));

    // R12
    a_r12_grant_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && (op_stb != '0) == (grant != '0));
endmodule

// File: tb/sim_acc_link_unit.sv
module sim_acc_link_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic [10:0] op_stb;
    logic [15:0] dr_val;
    logic [7:0]  in_char;
    logic [15:0] acc;
    logic        link, cond_pos, cond_neg, cond_zero, cond_ezero;

    int n_run  = 0;
    int n_fail = 0;
    logic [15:0] m_ac;
    logic        m_e;

    always #5 clk = ~clk;

    acc_link_unit u0 (
        .clk(clk), .rst(rst), .op_stb(op_stb), .dr_val(dr_val), .in_char(in_char),
        .acc(acc), .link(link), .cond_pos(cond_pos), .cond_neg(cond_neg),
        .cond_zero(cond_zero), .cond_ezero(cond_ezero)
    );

    function automatic logic [15:0] pat(input int i);
        case (i)
            0: pat = 16'h0000;
            1: pat = 16'hFFFF;
            2: pat = 16'h8000;
            3: pat = 16'h0001;
            4: pat = 16'h7FFF;
            5: pat = 16'hAAAA;
            6: pat = 16'h5555;
            default: pat = 16'h1234;
        endcase
    endfunction

    function automatic string tag(input int k);
        case (k)
            0: tag = "R3";
            1: tag = "R2";
            2: tag = "R4";
            3: tag = "R5";
            4: tag = "R10";
            5: tag = "R9";
            6: tag = "R8";
            7, 9: tag = "R7/R6";
            8, 10: tag = "R6/R7";
            default: tag = "R12";
        endcase
    endfunction

    // Reference model of one edge: {e, ac}
    function automatic logic [16:0] ref_next(input logic [10:0] s, input logic [15:0] a,
                                             input logic e, input logic [15:0] d,
                                             input logic [7:0] c);
        logic [16:0] r;
        int top;
        r = {e, a};
        top = -1;
        for (int i = 0; i < 11; i++) if (s[i]) top = i;
        case (top)
            10: r = {e, 16'h0000};
            9:  r = {1'b0, a};
            8:  r = {e, ~a};
            7:  r = {~e, a};
            6:  r = {a[0], e, a[15:1]};
            5:  r = {a[15], a[14:0], e};
            4:  r = {e, a + 16'h0001};
            3:  r = {e, a[15:8], c};
            2:  r = {e, d};
            1:  r = {1'b0, a} + {1'b0, d};
            0:  r = {e, a & d};
            default: r = {e, a};
        endcase
        return r;
    endfunction

    task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [10:0] s, input logic [15:0] d, input logic [7:0] c,
                         input string req);
        logic [16:0] exp;
        @(negedge clk);
        op_stb = s; dr_val = d; in_char = c;
        exp = ref_next(s, m_ac, m_e, d, c);
        @(negedge clk);
        op_stb = '0;
        {m_e, m_ac} = exp;
        chk(req, {link, acc}, exp);
    endtask

    task automatic set_state(input logic [15:0] a, input logic e);
        apply(11'h004, a, 8'h00, "R4");
        apply(11'h200, 16'h0, 8'h00, "R6");
        if (e) apply(11'h080, 16'h0, 8'h00, "R7");
        n_run++;
        if ({cond_pos, cond_neg, cond_zero, cond_ezero} !==
            {~a[15], a[15], a == 16'h0, ~e}) begin
            n_fail++;
            $display("FAIL R11 actual=%b expected=%b",
                     {cond_pos, cond_neg, cond_zero, cond_ezero},
                     {~a[15], a[15], a == 16'h0, ~e});
        end
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        rst = 1'b1; op_stb = '0; dr_val = '0; in_char = '0;
        @(negedge clk); @(negedge clk);
        chk("R1", {link, acc}, 17'h0);
        rst = 1'b0;
        m_ac = '0; m_e = 1'b0;

        // R1 again from a non-zero state
        set_state(16'hBEEF, 1'b1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_ac = '0; m_e = 1'b0;
        chk("R1", {link, acc}, 17'h0);

        // Every single operation over pattern pairs and both link values
        for (int k = 0; k < 11; k++)
            for (int a = 0; a < 8; a++)
                for (int d = 0; d < 8; d++)
                    for (int e = 0; e < 2; e++) begin
                        set_state(pat(a), e[0]);
                        apply(11'(1) << k, pat(d), pat(d)[11:4], tag(k));
                    end

        // R10 wrap with link set and clear
        set_state(16'hFFFF, 1'b1);
        apply(11'h010, 16'h0, 8'h0, "R10");
        set_state(16'hFFFF, 1'b0);
        apply(11'h010, 16'h0, 8'h0, "R10");

        // R12 idle hold
        set_state(16'h4321, 1'b1);
        apply(11'h000, 16'hFFFF, 8'hFF, "R12");
        apply(11'h000, 16'h0000, 8'h00, "R12");

        // R12 overlapping strobes
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            apply(lfsr[10:0] | 11'(lfsr[15:14]), {lfsr[7:0], lfsr[15:8]},
                  lfsr[12:5], "R12");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule